// File: doc/BRIEF.md
# Boot-Aware Window Watchdog with Reset Escalation

This block supervises software with a window watchdog whose availability depends on the boot mode. After every reset it starts a long open window in which a service strobe is always accepted. After that it alternates between a closed window, in which a service counts as a fault, and an open window, in which a service is required. A fault raises a one-cycle reset request for the system reset controller, which is expected to answer with a system reset. The watchdog then starts again from the long window.

In user mode an enable request locks the watchdog on, so that no later mode change or synchronisation can stop it. While it is not locked, debug mode stops it. In the bootstrap-wait mode it keeps running until a host-synchronised strobe arrives. That strobe stops it and raises a frozen-status flag. Both the stopped state and the flag last until the next system reset. A counter of consecutive faults sits in a separate reset domain: it survives system resets and is cleared only by power-on reset or by a service accepted in a normal open window. When a fault occurs with the counter already at its limit, the block raises a sticky sleep request instead of another reset request. Every pin is a plain control or status level or strobe. No data moves through the block, so it has no valid/ready interface and no back-pressure.

Top module: `boot_wdog_guard`

## Requirements
- R1: After power-on reset (`por_n` low), `rst_req`, `frozen` and `sleep_req` are 0. After a system reset (`rst_n` low), `rst_req` and `frozen` are 0. Either reset restarts the timer in the long open window.
- R2: During the first LONG_WIN cycles after a reset, a `kick` is always accepted and starts a closed window. Without a kick, the LONG_WIN-th rising edge after reset release is a fault.
- R3: In normal operation a closed window of CLOSED_WIN cycles is followed by an open window of OPEN_WIN cycles. A kick in the closed window is a fault. A kick in any open-window cycle, including the last one, is accepted and restarts the closed window. Reaching the end of the open window without a kick is a fault.
- R4: A fault drives `rst_req` high for exactly the one cycle after the faulting edge, and the timer restarts in the long open window.
- R5: `mode` encoding: 2'b00 user, 2'b01 debug, 2'b10 bootstrap-wait, 2'b11 treated as user. An `en_req` strobe in user mode, while the watchdog is running, locks it on. After that, debug mode and `host_sync` neither stop it nor set `frozen`.
- R6: While the watchdog is not locked, debug mode stops it. No fault is raised after that, and `frozen` stays 0.
- R7: In bootstrap-wait mode the unlocked watchdog keeps running and faults as usual. A `host_sync` strobe in that mode stops it and sets `frozen`. A `host_sync` in any other mode is ignored.
- R8: The stopped state and `frozen` hold through later mode changes and are cleared only by a reset. If a stop occurs in the same cycle as a timeout, the stop wins and no fault is raised.
- R9: The consecutive-fault count survives `rst_n` and is cleared by `por_n`. It is also cleared by a kick accepted in a normal open window, but not by a kick in the long open window.
- R10: Faults raise `rst_req` while the count is below ESC_LIMIT, and each such fault increments the count. A fault with the count at ESC_LIMIT raises `sleep_req` instead. `sleep_req` stays high until `por_n`, stops the watchdog, and suppresses any further `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, async, active low; clears the escalation domain |
| rst_n | input | 1 | System reset (any cause), async, active low |
| mode | input | 2 | Boot mode: 00 user, 01 debug, 10 bootstrap-wait, 11 as user |
| en_req | input | 1 | Enable/lock request strobe |
| host_sync | input | 1 | Host synchronisation strobe |
| kick | input | 1 | Service strobe |
| rst_req | output | 1 | One-cycle watchdog reset request |
| frozen | output | 1 | Status frozen after host synchronisation |
| sleep_req | output | 1 | Sticky low-power request after escalation |

## Verification
Two pairs of functions can meet in one cycle. In the first pair, a stop and a timeout coincide. The bench drives `host_sync` in bootstrap-wait mode on exactly the edge where the long window expires, and expects `frozen` high with no `rst_req`. In the second pair, a service and the end of the open window coincide. The bench kicks on the last open-window cycle and expects no fault, and a reference model running in the bench is compared against every output on every clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    MODE_USER     = 2'b00,
    MODE_DEBUG    = 2'b01,
    MODE_BOOTWAIT = 2'b10,
    MODE_ALT      = 2'b11
  } boot_mode_e;

  typedef enum logic [1:0] {
    PH_LONG   = 2'd0,
    PH_CLOSED = 2'd1,
    PH_OPEN   = 2'd2
  } win_phase_e;

  function automatic int unsigned win_cnt_width(input int unsigned a,
                                                input int unsigned b,
                                                input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/wdg_mode_gate.sv
module wdg_mode_gate
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       en_req,
  input  logic       host_sync,
  output logic       run_en,
  output logic       frozen
);

  boot_mode_e cur_mode;
  logic locked_q, stopped_q, frozen_q;
  logic stop_now, freeze_now, lock_now, user_like;

  always_comb begin
    cur_mode   = boot_mode_e'(mode);
    user_like  = (cur_mode == MODE_USER) || (cur_mode == MODE_ALT);
    stop_now   = !locked_q &&
                 ((cur_mode == MODE_DEBUG) ||
                  ((cur_mode == MODE_BOOTWAIT) && host_sync));
    freeze_now = !locked_q && !stopped_q &&
                 (cur_mode == MODE_BOOTWAIT) && host_sync;
    lock_now   = !locked_q && !stopped_q && user_like && en_req;
    run_en     = !stopped_q && !stop_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q  <= 1'b0;
      stopped_q <= 1'b0;
      frozen_q  <= 1'b0;
    end else begin
      if (stop_now)   stopped_q <= 1'b1;
      if (freeze_now) frozen_q  <= 1'b1;
      if (lock_now)   locked_q  <= 1'b1;
    end
  end

  assign frozen = frozen_q;

  // R5
  lock_excludes_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> !stopped_q);

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |=> frozen_q);

endmodule

// File: rtl/wdg_window_timer.sv
module wdg_window_timer
  import wdg_pkg::*;
#(
  parameter int unsigned LONG_WIN   = 4096,
  parameter int unsigned CLOSED_WIN = 256,
  parameter int unsigned OPEN_WIN   = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic kick,
  output logic fault,
  output logic serviced
);

  localparam int unsigned CNT_W = win_cnt_width(LONG_WIN, CLOSED_WIN, OPEN_WIN);
  localparam logic [CNT_W-1:0] LONG_LAST   = CNT_W'(LONG_WIN - 1);
  localparam logic [CNT_W-1:0] CLOSED_LAST = CNT_W'(CLOSED_WIN - 1);
  localparam logic [CNT_W-1:0] OPEN_LAST   = CNT_W'(OPEN_WIN - 1);

  win_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic at_last, bad_kick, expired, good_kick;

  always_comb begin
    unique case (phase_q)
      PH_CLOSED: last = CLOSED_LAST;
      PH_OPEN:   last = OPEN_LAST;
      default:   last = LONG_LAST;
    endcase
    at_last   = (cnt_q == last);
    bad_kick  = tick_en && kick && (phase_q == PH_CLOSED);
    expired   = tick_en && !kick && at_last && (phase_q != PH_CLOSED);
    good_kick = tick_en && kick && (phase_q != PH_CLOSED);
    fault     = bad_kick || expired;
    serviced  = good_kick && (phase_q == PH_OPEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LONG;
      cnt_q   <= '0;
    end else if (fault) begin
      phase_q <= PH_LONG;
      cnt_q   <= '0;
    end else if (good_kick) begin
      phase_q <= PH_CLOSED;
      cnt_q   <= '0;
    end else if (tick_en) begin
      if (at_last) begin
        phase_q <= PH_OPEN;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R3
  open_kick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && kick && phase_q == PH_OPEN) |=> (phase_q == PH_CLOSED && cnt_q == '0));

  // R2
  long_window_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !kick && phase_q == PH_LONG && cnt_q != LONG_LAST) |=> (phase_q == PH_LONG));

endmodule

// File: rtl/wdg_escalation.sv
module wdg_escalation #(
  parameter int unsigned ESC_LIMIT = 5
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic fault,
  input  logic serviced,
  output logic rst_req,
  output logic sleep_req
);

  localparam int unsigned ESC_W = $clog2(ESC_LIMIT + 1);
  localparam logic [ESC_W-1:0] ESC_TOP = ESC_W'(ESC_LIMIT);

  logic [ESC_W-1:0] esc_q;
  logic sleep_q, rst_req_q;
  logic at_top, issue_rst;

  always_comb begin
    at_top    = (esc_q == ESC_TOP);
    issue_rst = fault && !at_top;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      esc_q   <= '0;
      sleep_q <= 1'b0;
    end else if (fault) begin
      if (at_top) sleep_q <= 1'b1;
      else        esc_q   <= esc_q + ESC_W'(1);
    end else if (serviced) begin
      esc_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= issue_rst;
  end

  assign rst_req   = rst_req_q;
  assign sleep_req = sleep_q;

  // R4
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);

  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    sleep_q |=> sleep_q);

  // R10
  sleep_blocks_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> !rst_req_q);

  // R9
  service_clears_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    serviced |=> (esc_q == '0));

endmodule

// File: rtl/boot_wdog_guard.sv
module boot_wdog_guard #(
  parameter int unsigned LONG_WIN   = 4096,
  parameter int unsigned CLOSED_WIN = 256,
  parameter int unsigned OPEN_WIN   = 256,
  parameter int unsigned ESC_LIMIT  = 5
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       en_req,
  input  logic       host_sync,
  input  logic       kick,
  output logic       rst_req,
  output logic       frozen,
  output logic       sleep_req
);

  logic run_en, tick_en, fault, serviced;

  wdg_mode_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .en_req    (en_req),
    .host_sync (host_sync),
    .run_en    (run_en),
    .frozen    (frozen)
  );

  assign tick_en = run_en && !sleep_req;

  wdg_window_timer #(
    .LONG_WIN   (LONG_WIN),
    .CLOSED_WIN (CLOSED_WIN),
    .OPEN_WIN   (OPEN_WIN)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .kick     (kick),
    .fault    (fault),
    .serviced (serviced)
  );

  wdg_escalation #(
    .ESC_LIMIT (ESC_LIMIT)
  ) u_esc (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .fault     (fault),
    .serviced  (serviced),
    .rst_req   (rst_req),
    .sleep_req (sleep_req)
  );

  // R6
  no_fault_when_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en || sleep_req) |=> !rst_req);

endmodule

// File: tb/test_boot_wdog_guard.sv
`timescale 1ns/1ps
module test_boot_wdog_guard;

  localparam int LONG = 48;
  localparam int CW   = 8;
  localparam int OW   = 12;
  localparam int LIM  = 5;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic en_req = 1'b0, host_sync = 1'b0, kick = 1'b0;
  logic rst_req, frozen, sleep_req;

  int checks = 0, fails = 0, cycles = 0;

  boot_wdog_guard #(.LONG_WIN(LONG), .CLOSED_WIN(CW), .OPEN_WIN(OW), .ESC_LIMIT(LIM)) i_boot_wdog_guard (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .mode(mode), .en_req(en_req),
    .host_sync(host_sync), .kick(kick), .rst_req(rst_req), .frozen(frozen),
    .sleep_req(sleep_req)
  );

  always #10 clk = ~clk;

  // Behavioural reference model
  int  m_phase, m_cnt, m_esc, m_lim;
  bit  m_stop, m_frozen, m_lock, m_sleep, m_rst;
  bit  m_fault, m_stop_now, m_active;

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n) begin
      m_phase = 0; m_cnt = 0; m_esc = 0; m_sleep = 0;
      m_stop = 0; m_frozen = 0; m_lock = 0; m_rst = 0;
    end else if (!rst_n) begin
      m_phase = 0; m_cnt = 0;
      m_stop = 0; m_frozen = 0; m_lock = 0; m_rst = 0;
    end else begin
      m_stop_now = !m_lock && (mode == 2'b01 || (mode == 2'b10 && host_sync));
      m_active = !m_stop && !m_stop_now && !m_sleep;
      m_rst = 0;
      m_fault = 0;
      if (m_active) begin
        m_lim = (m_phase == 0) ? LONG : (m_phase == 1) ? CW : OW;
        if (kick) begin
          if (m_phase == 1) m_fault = 1;
          else begin
            if (m_phase == 2) m_esc = 0;
            m_phase = 1; m_cnt = 0;
          end
        end else if (m_cnt == m_lim - 1) begin
          if (m_phase == 1) begin m_phase = 2; m_cnt = 0; end
          else m_fault = 1;
        end else m_cnt++;
        if (m_fault) begin
          m_phase = 0; m_cnt = 0;
          if (m_esc == LIM) m_sleep = 1;
          else begin m_rst = 1; m_esc++; end
        end
      end
      if (!m_lock && !m_stop && mode == 2'b10 && host_sync) m_frozen = 1;
      if (!m_lock && !m_stop && (mode == 2'b00 || mode == 2'b11) && en_req) m_lock = 1;
      if (m_stop_now) m_stop = 1;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    check("R4 rst_req vs model", rst_req, m_rst);
    check("R7 frozen vs model", frozen, m_frozen);
    check("R10 sleep_req vs model", sleep_req, m_sleep);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_kick();
    kick = 1'b1; step(); kick = 1'b0;
  endtask

  task automatic pulse_sync();
    host_sync = 1'b1; step(); host_sync = 1'b0;
  endtask

  task automatic pulse_en();
    en_req = 1'b1; step(); en_req = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0; rst_n = 1'b0;
    step(2);
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  task automatic do_sysreset();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
  endtask

  // Fault from a fresh long window: long-window kick (accepted), then closed-window kick
  task automatic kick_fault();
    do_sysreset();
    pulse_kick();
    pulse_kick();
  endtask

  initial begin
    do_por();
    // R1 reset state
    check("R1 rst_req after por", rst_req, 1'b0);
    check("R1 frozen after por", frozen, 1'b0);
    check("R1 sleep_req after por", sleep_req, 1'b0);

    // R2 / R4 long window expiry, one-cycle pulse
    step(LONG - 1);
    check("R2 no fault before long window ends", rst_req, 1'b0);
    step();
    check("R4 rst_req on long window expiry", rst_req, 1'b1);
    step();
    check("R4 rst_req single cycle", rst_req, 1'b0);

    // R2 kick in long window accepted, R3 kick in closed window faults
    do_por();
    step(10);
    pulse_kick();
    check("R2 long-window kick accepted", rst_req, 1'b0);
    pulse_kick();
    check("R3 closed-window kick faults", rst_req, 1'b1);

    // R3 proper servicing, kick on last open cycle
    do_por();
    step(5);
    pulse_kick();
    for (int k = 0; k < 3; k++) begin
      step(CW + OW - 1);
      pulse_kick();
      check("R3 kick on last open cycle accepted", rst_req, 1'b0);
    end
    step(CW + OW - 1);
    check("R3 no fault before open window ends", rst_req, 1'b0);
    step();
    check("R3 open window expiry faults", rst_req, 1'b1);

    // R9 service in open window clears count; R10 escalation
    do_por();
    for (int k = 0; k < 4; k++) kick_fault();
    do_sysreset();
    pulse_kick();
    step(CW);
    pulse_kick();
    check("R9 open service no fault", rst_req, 1'b0);
    for (int k = 0; k < LIM; k++) begin
      kick_fault();
      check("R9 fault after cleared count requests reset", rst_req, 1'b1);
    end
    kick_fault();
    check("R10 fault at limit gives no reset", rst_req, 1'b0);
    check("R10 fault at limit raises sleep", sleep_req, 1'b1);
    do_sysreset();
    check("R10 sleep survives system reset", sleep_req, 1'b1);
    step(LONG + 4);
    check("R10 no reset while asleep", rst_req, 1'b0);
    do_por();
    check("R9 por clears sleep and count", sleep_req, 1'b0);

    // R6 debug mode stops unlocked watchdog; R8 persistence
    mode = 2'b01;
    do_por();
    step(LONG + CW + 5);
    check("R6 debug stops watchdog", rst_req, 1'b0);
    check("R6 debug leaves frozen low", frozen, 1'b0);
    mode = 2'b00;
    step(LONG + 2);
    check("R8 stop persists after mode change", rst_req, 1'b0);
    do_sysreset();
    step(LONG - 1);
    check("R8 reset restarts watchdog (pre)", rst_req, 1'b0);
    step();
    check("R8 reset restarts watchdog", rst_req, 1'b1);

    // R7 bootstrap-wait keeps running, host sync freezes
    mode = 2'b10;
    do_por();
    step(LONG);
    check("R7 bootstrap-wait keeps running", rst_req, 1'b1);
    do_sysreset();
    step(3);
    pulse_sync();
    check("R7 host sync sets frozen", frozen, 1'b1);
    step(LONG + 2);
    check("R7 host sync stops watchdog", rst_req, 1'b0);
    mode = 2'b00;
    step(2);
    check("R8 frozen persists after mode change", frozen, 1'b1);
    do_sysreset();
    check("R8 system reset clears frozen", frozen, 1'b0);

    // R7 host sync ignored outside bootstrap-wait
    do_por();
    pulse_sync();
    check("R7 host sync ignored in user mode", frozen, 1'b0);
    step(LONG - 1);
    check("R7 watchdog still runs after ignored sync", rst_req, 1'b1);

    // R5 lock survives debug and host sync
    do_por();
    pulse_en();
    mode = 2'b01;
    step(LONG - 1);
    check("R5 locked watchdog runs in debug", rst_req, 1'b1);
    mode = 2'b10;
    pulse_sync();
    check("R5 locked watchdog ignores host sync", frozen, 1'b0);
    step(LONG - 1);
    check("R5 locked watchdog keeps faulting", rst_req, 1'b1);

    // R8 host sync on the timeout edge: stop wins
    mode = 2'b10;
    do_por();
    step(LONG - 1);
    pulse_sync();
    check("R8 same-cycle stop suppresses fault", rst_req, 1'b0);
    check("R8 same-cycle stop sets frozen", frozen, 1'b1);

    step(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule